// File: doc/BRIEF.md
# Calendar Clock Alarm and Tick Interrupt Unit

This block holds the interrupt logic of a calendar clock. The counters that keep time are outside the block. They present eight current time fields: seconds, minutes, hours, day of month, day of week, day of year, month and year. Software supplies a target value for each field. The block raises a pending alarm once, when every field that is not excluded first equals its target.

Separately, a per-field enable selects which fields raise a tick interrupt each time their value moves. Both kinds of event are held as sticky flags in an interrupt location register, which software clears by writing ones.

There is one write port. `wr_addr_i` selects a register: 0 is the alarm exclusion mask, 1 is the tick enables and 2 is the interrupt location register. Address 3 selects nothing. The single interrupt line is the OR of the two flags.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, both flags and `irq_o` are low. The exclusion mask resets to all ones, so the alarm is off. All tick enables reset to zero.
- R2: The alarm flag (`int_flags_o[1]`) sets on the clock edge that follows the first cycle in which every included field equals its target, having differed in the cycle before.
- R3: When mask bit i is one, field i takes no part in the comparison. The bit positions are: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. When mask bit i is zero, a difference in field i alone prevents the alarm.
- R4: While the match persists, the alarm does not set again after it has been cleared.
- R5: A mask of all ones never sets the alarm flag, even when every field equals its target.
- R6: The tick enables use the same bit positions as the mask. When the enable for a field is set, any change of that field's value between two clock edges sets the tick flag (`int_flags_o[0]`) on the following edge.
- R7: A change in a field whose tick enable is zero leaves the tick flag clear.
- R8: A write to address 2 clears the tick flag where data bit 0 is one, and clears the alarm flag where data bit 1 is one. A zero bit leaves its flag unchanged.
- R9: A flag stays set until it is cleared. `irq_o` is high exactly when at least one flag is set.
- R10: A new event in the same cycle as a clear of its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | SEC_W | Current seconds |
| min_i | input | MIN_W | Current minutes |
| hour_i | input | HOUR_W | Current hours |
| mday_i | input | MDAY_W | Current day of month |
| wday_i | input | WDAY_W | Current day of week |
| yday_i | input | YDAY_W | Current day of year |
| mon_i | input | MON_W | Current month |
| year_i | input | YEAR_W | Current year |
| alm_sec_i | input | SEC_W | Alarm target, seconds |
| alm_min_i | input | MIN_W | Alarm target, minutes |
| alm_hour_i | input | HOUR_W | Alarm target, hours |
| alm_mday_i | input | MDAY_W | Alarm target, day of month |
| alm_wday_i | input | WDAY_W | Alarm target, day of week |
| alm_yday_i | input | YDAY_W | Alarm target, day of year |
| alm_mon_i | input | MON_W | Alarm target, month |
| alm_year_i | input | YEAR_W | Alarm target, year |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mask, 1 tick enables, 2 interrupt location |
| wr_data_i | input | 8 | Write data |
| int_flags_o | output | 2 | Bit 0 is the tick flag, bit 1 is the alarm flag |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default widths: 6/6/5/5/3/9/4/12 bits. These widths place the year field, the widest at 12 bits, at the top of the padded compare width, alongside the narrow day-of-week field. Every field index from 0 to 7 therefore gets its own target mismatch and its own tick in a per-field loop, and each mask and enable bit is tied to the right field. With the default year width, year values above 255 can be driven, which shows the comparison is not cut to the byte-wide register width.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned REG_W      = 8;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_TICK  = 2'd1,
    SEL_FLAGS = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned FLAG_TICK = 0;
  localparam int unsigned FLAG_ALM  = 1;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rtc_field_unit.sv
module rtc_field_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] tgt_i,
  input  logic         seen_i,
  output logic         eq_o,
  output logic         step_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  assign eq_o   = (cur_i == tgt_i);
  assign step_o = seen_i && (cur_i != prev_q);

  a_r6_no_step_when_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_i && $stable(cur_i)) |-> !step_o);
endmodule

// File: rtl/rtc_alarm_edge.sv
module rtc_alarm_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] eq_i,
  input  logic [N-1:0] mask_i,
  output logic         alm_set_o
);
  logic hit, hit_q;

  // all masked means disabled, not a permanent match
  assign hit = (&(eq_i | mask_i)) && !(&mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  assign alm_set_o = hit && !hit_q;

  a_r5_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !alm_set_o);
  a_r4_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_set_o |=> !alm_set_o);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_set_i,
  input  logic       alm_set_i,
  input  logic [1:0] clr_i,
  output logic [1:0] flags_o,
  output logic       irq_o
);
  import rtc_alarm_pkg::*;

  logic [1:0] flag_q, set_v;

  assign set_v[FLAG_TICK] = tick_set_i;
  assign set_v[FLAG_ALM]  = alm_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_v | (flag_q & ~clr_i);
  end

  assign flags_o = flag_q;
  assign irq_o   = |flag_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_set_i |=> flag_q[FLAG_TICK]);
  a_r8_alm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[FLAG_ALM] && !alm_set_i) |=> !flag_q[FLAG_ALM]);
  a_r9_alm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FLAG_ALM] && !clr_i[FLAG_ALM]) |=> flag_q[FLAG_ALM]);
  a_r9_tick_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FLAG_TICK] && !clr_i[FLAG_TICK]) |=> flag_q[FLAG_TICK]);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned SEC_W  = 6,
  parameter int unsigned MIN_W  = 6,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned MDAY_W = 5,
  parameter int unsigned WDAY_W = 3,
  parameter int unsigned YDAY_W = 9,
  parameter int unsigned MON_W  = 4,
  parameter int unsigned YEAR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [MDAY_W-1:0] mday_i,
  input  logic [WDAY_W-1:0] wday_i,
  input  logic [YDAY_W-1:0] yday_i,
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  input  logic [SEC_W-1:0]  alm_sec_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic [HOUR_W-1:0] alm_hour_i,
  input  logic [MDAY_W-1:0] alm_mday_i,
  input  logic [WDAY_W-1:0] alm_wday_i,
  input  logic [YDAY_W-1:0] alm_yday_i,
  input  logic [MON_W-1:0]  alm_mon_i,
  input  logic [YEAR_W-1:0] alm_year_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [1:0]        int_flags_o,
  output logic              irq_o
);
  import rtc_alarm_pkg::*;

  localparam int unsigned N  = NUM_FIELDS;
  localparam int unsigned FW = max_of(max_of(max_of(SEC_W, MIN_W), max_of(HOUR_W, MDAY_W)),
                                      max_of(max_of(WDAY_W, YDAY_W), max_of(MON_W, YEAR_W)));

  logic [FW-1:0] cur_f [N];
  logic [FW-1:0] tgt_f [N];

  // field order fixes mask and tick-enable bit positions
  assign cur_f[0] = FW'(sec_i);   assign tgt_f[0] = FW'(alm_sec_i);
  assign cur_f[1] = FW'(min_i);   assign tgt_f[1] = FW'(alm_min_i);
  assign cur_f[2] = FW'(hour_i);  assign tgt_f[2] = FW'(alm_hour_i);
  assign cur_f[3] = FW'(mday_i);  assign tgt_f[3] = FW'(alm_mday_i);
  assign cur_f[4] = FW'(wday_i);  assign tgt_f[4] = FW'(alm_wday_i);
  assign cur_f[5] = FW'(yday_i);  assign tgt_f[5] = FW'(alm_yday_i);
  assign cur_f[6] = FW'(mon_i);   assign tgt_f[6] = FW'(alm_mon_i);
  assign cur_f[7] = FW'(year_i);  assign tgt_f[7] = FW'(alm_year_i);

  logic [REG_W-1:0] mask_q, tick_en_q;
  logic             seen_q;
  logic [N-1:0]     eq_v, step_v;
  logic             tick_set, alm_set;
  logic [1:0]       clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      tick_en_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (wr_en_i && reg_sel_e'(wr_addr_i) == SEL_MASK) mask_q    <= wr_data_i;
      if (wr_en_i && reg_sel_e'(wr_addr_i) == SEL_TICK) tick_en_q <= wr_data_i;
    end
  end

  assign clr = (wr_en_i && reg_sel_e'(wr_addr_i) == SEL_FLAGS) ? wr_data_i[1:0] : 2'b00;

  for (genvar g = 0; g < N; g++) begin : g_field
    rtc_field_unit #(.W(FW)) i_field (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (cur_f[g]),
      .tgt_i  (tgt_f[g]),
      .seen_i (seen_q),
      .eq_o   (eq_v[g]),
      .step_o (step_v[g])
    );
  end

  assign tick_set = |(step_v & tick_en_q[N-1:0]);

  rtc_alarm_edge #(.N(N)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eq_i      (eq_v),
    .mask_i    (mask_q[N-1:0]),
    .alm_set_o (alm_set)
  );

  rtc_irq_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_set_i (tick_set),
    .alm_set_i  (alm_set),
    .clr_i      (clr),
    .flags_o    (int_flags_o),
    .irq_o      (irq_o)
  );

  a_r7_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_flags_o[0] && !(|(step_v & tick_en_q[N-1:0]))) |=> !int_flags_o[0]);
endmodule

// File: tb/test_rtc_alarm_cmp.sv
module test_rtc_alarm_cmp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] tf [8];
  logic [11:0] af [8];
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] flags;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_cmp i_rtc_alarm_cmp (
    .clk_i(clk), .rst_ni(rst_n),
    .sec_i(tf[0][5:0]), .min_i(tf[1][5:0]), .hour_i(tf[2][4:0]), .mday_i(tf[3][4:0]),
    .wday_i(tf[4][2:0]), .yday_i(tf[5][8:0]), .mon_i(tf[6][3:0]), .year_i(tf[7]),
    .alm_sec_i(af[0][5:0]), .alm_min_i(af[1][5:0]), .alm_hour_i(af[2][4:0]),
    .alm_mday_i(af[3][4:0]), .alm_wday_i(af[4][2:0]), .alm_yday_i(af[5][8:0]),
    .alm_mon_i(af[6][3:0]), .alm_year_i(af[7]),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .int_flags_o(flags), .irq_o(irq)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got {irq,flags}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic base_time();
    tf[0] = 12'd17; tf[1] = 12'd42; tf[2] = 12'd9;  tf[3] = 12'd28;
    tf[4] = 12'd5;  tf[5] = 12'd300; tf[6] = 12'd11; tf[7] = 12'd2047;
    for (int i = 0; i < 8; i++) af[i] = tf[i];
  endtask

  task automatic t_reset();
    check("R1 flags at reset", {irq, flags}, 3'b000);
    step(3);  // targets equal time, mask all ones
    check("R1 mask resets to all ones", {irq, flags}, 3'b000);
    tf[0] = tf[0] + 1; step(2);
    check("R1 tick enables reset to zero", {irq, flags}, 3'b000);
  endtask

  task automatic t_alarm_basic();
    base_time(); af[0] = 12'd30;
    wr(2'd0, 8'h00); step();
    check("R2 no alarm on mismatch", {irq, flags}, 3'b000);
    tf[0] = 12'd30; step();
    check("R2 alarm sets on match", {irq, flags}, 3'b110);
    step(3);
    check("R9 alarm flag sticky", {irq, flags}, 3'b110);
    wr(2'd2, 8'h02);
    check("R8 alarm cleared by one in bit 1", {irq, flags}, 3'b000);
    step(4);
    check("R4 no repeat while match persists", {irq, flags}, 3'b000);
  endtask

  task automatic t_mask_bits();
    for (int i = 0; i < 8; i++) begin
      base_time(); af[i] = tf[i] ^ 12'd1;
      wr(2'd0, 8'h00); wr(2'd2, 8'h03); step();
      check($sformatf("R3 field %0d compared when unmasked", i), {irq, flags}, 3'b000);
      wr(2'd0, 8'(1 << i)); step();
      check($sformatf("R3 mask bit %0d excludes field", i), {irq, flags}, 3'b110);
      wr(2'd2, 8'h02);
      wr(2'd0, ~8'(1 << i)); step(2);
      check($sformatf("R3 only field %0d differs, compared", i), {irq, flags}, 3'b000);
    end
  endtask

  task automatic t_all_masked();
    base_time(); af[2] = 12'd3;
    wr(2'd0, 8'hFF); wr(2'd2, 8'h03);
    af[2] = tf[2]; step(3);
    check("R5 all masked never alarms", {irq, flags}, 3'b000);
    wr(2'd0, 8'h00); step();
    check("R5 unmasking then alarms", {irq, flags}, 3'b110);
    wr(2'd2, 8'h02);
  endtask

  task automatic t_ticks();
    base_time(); wr(2'd0, 8'hFF); wr(2'd2, 8'h03);
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, 8'(1 << i));
      tf[(i + 1) % 8] = tf[(i + 1) % 8] + 12'd1; step();
      check($sformatf("R7 field %0d change without enable", (i + 1) % 8), {irq, flags}, 3'b000);
      tf[i] = tf[i] + 12'd1; step();
      check($sformatf("R6 tick on enabled field %0d", i), {irq, flags}, 3'b101);
      step(2);
      check($sformatf("R9 tick sticky field %0d", i), {irq, flags}, 3'b101);
      wr(2'd2, 8'h01);
      check($sformatf("R8 tick cleared field %0d", i), {irq, flags}, 3'b000);
    end
  endtask

  task automatic t_clear_rules();
    base_time(); wr(2'd1, 8'h01); wr(2'd0, 8'h00); wr(2'd2, 8'h03);
    af[0] = tf[0] + 12'd1; step(); wr(2'd2, 8'h03);
    tf[0] = tf[0] + 12'd1; step();  // tick and alarm together
    check("R6 R2 both events", {irq, flags}, 3'b111);
    wr(2'd2, 8'h00);
    check("R8 zero write keeps flags", {irq, flags}, 3'b111);
    wr(2'd2, 8'h01);
    check("R9 irq from alarm alone", {irq, flags}, 3'b110);
    wr(2'd2, 8'h02);
    check("R9 irq low with no flags", {irq, flags}, 3'b000);
    tf[0] = tf[0] + 12'd1;
    wr(2'd2, 8'h01);  // event and clear on one edge
    check("R10 set beats clear", {irq, flags}, 3'b101);
    wr(2'd3, 8'h03);
    check("R8 address 3 writes nothing", {irq, flags}, 3'b101);
  endtask

  initial begin
    base_time();
    for (int i = 0; i < 8; i++) begin tf[i] = '0; af[i] = '0; end
    step(2); rst_n = 1'b1; @(negedge clk);
    t_reset();
    t_alarm_basic();
    t_mask_bits();
    t_all_masked();
    t_ticks();
    t_clear_rules();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule